// File: doc/BRIEF.md
# Shared Prescaler Tick Generator

This block derives one tick-enable strobe per channel for a five-channel timer, all from a single base clock. There are two 8-bit prescalers. The first serves the two low channels and the second serves the three high channels. Each prescaler divides the base clock by its programmed value plus one. A free-running counter in each group advances on every prescaler strobe. Each channel picks a power-of-two tap of that counter through its own 4-bit select field.

Some select codes route an external tick input to the channel instead of the divider. A parameter bitmask marks which codes do this. The low group uses external input 0 and the high group uses external input 1. The external inputs are treated as synchronous to the base clock, and each rising edge gives one tick.

All channels of a group share one prescaler and one divider counter. Channels of the same group that use the same code therefore tick in the same cycle. A timer core consumes `tick_o` as a count enable.

Top module: `ptick_gen`

## Requirements
- R1: While `rst_ni` is low, every bit of `tick_o` is 0. Reset clears both prescaler counters, both divider counters and both edge detectors.
- R2: `cfg0_i[7:0]` is the prescale value of group 0, which serves channels 0 and 1. `cfg0_i[15:8]` is the prescale value of group 1, which serves channels 2, 3 and 4.
- R3: A prescale value P yields a prescaler strobe every P+1 base-clock cycles. P=0 yields a strobe every cycle. The first strobe comes in the first cycle after reset.
- R4: The select field of channel n is `cfg1_i[4n+3:4n]`. A non-external code C gives the channel a tick every (P+1)·2^(C+DIV_BASE) cycles, with DIV_BASE=1 by default.
- R5: A divider tick is registered. It appears in the cycle after a prescaler strobe in which the low C+DIV_BASE bits of the group's divider counter are all ones. That counter starts at 0 and counts prescaler strobes. As a result, same-group channels with equal codes tick together.
- R6: A code whose bit is set in EXT_MASK selects the external input. The default mask sets code 4 only. Channels 0 and 1 use `ext_tick_i[0]`, and channels 2 to 4 use `ext_tick_i[1]`.
- R7: An external-selected channel ticks for exactly one cycle. The tick comes in the cycle after `ext_tick_i` is seen high having been low the cycle before. An input held high gives a single tick, and a low input gives none.
- R8: A new prescale value takes effect only at the group's next strobe. The period already running completes with the old value.
- R9: Changing a channel's code takes effect from the next cycle. It does not disturb the group's counters or the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg0_i | input | 16 | Prescale values, group 0 low byte, group 1 high byte |
| cfg1_i | input | 20 | Per-channel 4-bit select fields |
| ext_tick_i | input | 2 | External tick sources for group 0 and group 1 |
| tick_o | output | 5 | Per-channel tick enable strobes |

## Verification
The bench first checks that period counts match (P+1)·2^(C+1) over windows that are whole multiples of each period. A design with the group split wrong, or with DIV_BASE ignored, would give counts off by a factor of two or taken from the other prescaler. It then changes the prescale value mid-period and changes select codes while the counters run. A design that reloads at once would give a short period, and one that resets the counter on a code change would shift the tick phase. Held-high and back-to-back external pulses expose a level-sensitive path, which would tick on every cycle the input stays high.

// File: rtl/ptick_pkg.sv
package ptick_pkg;
  localparam int unsigned NUM_GRP = 2;

  function automatic int unsigned grp_of(input int unsigned ch, input int unsigned split);
    return (ch < split) ? 0 : 1;
  endfunction
endpackage

// File: rtl/ptick_prescale.sv
module ptick_prescale #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] pre_val_i,
  output logic             stb_o
);
  logic [PRE_W-1:0] cnt_q;

  assign stb_o = (cnt_q == '0);

  // reload only at terminal count: a new value never cuts a period short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (stb_o) cnt_q <= pre_val_i;
    else            cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ptick_divchain.sv
module ptick_divchain #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_stb_i,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (pre_stb_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ptick_edge.sv
module ptick_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/ptick_chan_sel.sv
module ptick_chan_sel #(
  parameter int unsigned          MUX_W    = 4,
  parameter int unsigned          DIV_W    = 16,
  parameter int unsigned          DIV_BASE = 1,
  parameter logic [2**MUX_W-1:0]  EXT_MASK = 16'h0010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MUX_W-1:0] code_i,
  input  logic             pre_stb_i,
  input  logic [DIV_W-1:0] div_cnt_i,
  input  logic             ext_rise_i,
  output logic             tick_o
);
  localparam int unsigned EXP_W = $clog2(DIV_W + 1);

  logic [EXP_W-1:0] exp_w;
  logic [DIV_W-1:0] tap_mask;
  logic             div_hit;
  logic             sel_ext;
  logic             tick_d;

  assign exp_w   = EXP_W'(code_i) + EXP_W'(DIV_BASE);
  assign sel_ext = EXT_MASK[code_i];

  always_comb begin
    for (int i = 0; i < int'(DIV_W); i++) tap_mask[i] = (i < int'(exp_w));
  end

  // low exp bits all ones: the divider rolls over on this strobe
  assign div_hit = pre_stb_i & (&(div_cnt_i | ~tap_mask));
  assign tick_d  = sel_ext ? ext_rise_i : div_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= tick_d;
  end
endmodule

// File: rtl/ptick_gen.sv
module ptick_gen #(
  parameter int unsigned         NUM_CH    = 5,
  parameter int unsigned         GRP_SPLIT = 2,
  parameter int unsigned         PRE_W     = 8,
  parameter int unsigned         MUX_W     = 4,
  parameter int unsigned         DIV_BASE  = 1,
  parameter logic [2**MUX_W-1:0] EXT_MASK  = 16'h0010
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2*PRE_W-1:0]      cfg0_i,
  input  logic [NUM_CH*MUX_W-1:0] cfg1_i,
  input  logic [1:0]              ext_tick_i,
  output logic [NUM_CH-1:0]       tick_o
);
  import ptick_pkg::*;

  localparam int unsigned DIV_W = (2**MUX_W) - 1 + DIV_BASE;

  logic [NUM_GRP-1:0] pre_stb;
  logic [NUM_GRP-1:0] ext_rise;
  logic [DIV_W-1:0]   div_cnt [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    ptick_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pre_val_i(cfg0_i[g*PRE_W +: PRE_W]),
      .stb_o    (pre_stb[g])
    );

    ptick_divchain #(.DIV_W(DIV_W)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pre_stb_i(pre_stb[g]),
      .cnt_o    (div_cnt[g])
    );

    ptick_edge u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (ext_tick_i[g]),
      .rise_o(ext_rise[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GRP = grp_of(c, GRP_SPLIT);

    ptick_chan_sel #(
      .MUX_W   (MUX_W),
      .DIV_W   (DIV_W),
      .DIV_BASE(DIV_BASE),
      .EXT_MASK(EXT_MASK)
    ) u_sel (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .code_i    (cfg1_i[c*MUX_W +: MUX_W]),
      .pre_stb_i (pre_stb[GRP]),
      .div_cnt_i (div_cnt[GRP]),
      .ext_rise_i(ext_rise[GRP]),
      .tick_o    (tick_o[c])
    );
  end
endmodule

// File: rtl/ptick_gen_chk.sv
module ptick_gen_chk #(
  parameter int unsigned         NUM_CH   = 5,
  parameter int unsigned         PRE_W    = 8,
  parameter int unsigned         MUX_W    = 4,
  parameter logic [2**MUX_W-1:0] EXT_MASK = 16'h0010
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [2*PRE_W-1:0]      cfg0_i,
  input logic [NUM_CH*MUX_W-1:0] cfg1_i,
  input logic [1:0]              ext_tick_i,
  input logic [NUM_CH-1:0]       tick_o,
  input logic [1:0]              pre_stb
);
  logic [MUX_W-1:0] code0, code1, code2, code3;
  assign code0 = cfg1_i[0*MUX_W +: MUX_W];
  assign code1 = cfg1_i[1*MUX_W +: MUX_W];
  assign code2 = cfg1_i[2*MUX_W +: MUX_W];
  assign code3 = cfg1_i[3*MUX_W +: MUX_W];

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R1: assert (tick_o == '0);
  end

  assert_pre_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_stb[0] && cfg0_i[PRE_W-1:0] != '0) |=> !pre_stb[0]);

  assert_pre1_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_stb[1] && cfg0_i[2*PRE_W-1:PRE_W] != '0) |=> !pre_stb[1]);

  assert_div_needs_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!EXT_MASK[code0] && !pre_stb[0]) |=> !tick_o[0]);

  assert_same_code_lockstep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code2 == code3) |=> (tick_o[2] == tick_o[3]));

  assert_ext_low_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (EXT_MASK[code1] && !ext_tick_i[0]) |=> !tick_o[1]);
endmodule

bind ptick_gen ptick_gen_chk #(
  .NUM_CH  (NUM_CH),
  .PRE_W   (PRE_W),
  .MUX_W   (MUX_W),
  .EXT_MASK(EXT_MASK)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg0_i    (cfg0_i),
  .cfg1_i    (cfg1_i),
  .ext_tick_i(ext_tick_i),
  .tick_o    (tick_o),
  .pre_stb   (pre_stb)
);

// File: tb/ptick_gen_tb.sv
`timescale 1ns/1ps
module ptick_gen_tb;
  localparam int NCH = 5;
  localparam int DB  = 1;
  localparam int EXT_CODE = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cfg0_i = '0;
  logic [19:0] cfg1_i = '0;
  logic [1:0]  ext_tick_i = '0;
  logic [4:0]  tick_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference state
  int  pcnt [2];
  int  dcnt [2];
  bit  eprev [2];
  bit  exp_tick [NCH];

  always #4 clk_i = ~clk_i;

  ptick_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg0_i(cfg0_i),
    .cfg1_i(cfg1_i), .ext_tick_i(ext_tick_i), .tick_o(tick_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < 2; g++) begin pcnt[g] = 0; dcnt[g] = 0; eprev[g] = 0; end
      for (int c = 0; c < NCH; c++) exp_tick[c] = 0;
    end else begin
      bit pst [2];
      for (int g = 0; g < 2; g++) pst[g] = (pcnt[g] == 0);
      for (int c = 0; c < NCH; c++) begin
        int g, code, per;
        g = (c < 2) ? 0 : 1;
        code = (cfg1_i >> (4*c)) & 15;
        if (code == EXT_CODE) exp_tick[c] = ext_tick_i[g] && !eprev[g];
        else begin
          per = 1 << (code + DB);
          exp_tick[c] = pst[g] && ((dcnt[g] % per) == per - 1);
        end
      end
      for (int g = 0; g < 2; g++) begin
        if (pst[g]) begin
          pcnt[g] = (cfg0_i >> (8*g)) & 255;
          dcnt[g] = (dcnt[g] + 1) % 65536;
        end else pcnt[g] = pcnt[g] - 1;
        eprev[g] = ext_tick_i[g];
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && !done) begin
      for (int c = 0; c < NCH; c++) begin
        n_cmp++;
        if (tick_o[c] !== exp_tick[c]) begin
          n_bad++;
          $display("FAIL %s ch%0d cyc %0d: actual %0b expected %0b", phase, c, cyc, tick_o[c], exp_tick[c]);
        end
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic set_code(input int ch, input int code);
    @(negedge clk_i);
    cfg1_i[4*ch +: 4] = 4'(code);
  endtask

  task automatic count_win(input int ch, input int n, input int expv, input string req);
    int cnt = 0;
    repeat (n) begin
      @(negedge clk_i);
      #1;
      if (tick_o[ch]) cnt++;
    end
    n_cmp++;
    if (cnt != expv) begin
      n_bad++;
      $display("FAIL %s ch%0d tick count: actual %0d expected %0d", req, ch, cnt, expv);
    end
  endtask

  initial begin
    cfg0_i = {8'd3, 8'd1};
    cfg1_i = {4'd0, 4'd2, 4'd0, 4'd1, 4'd0};
    repeat (3) @(negedge clk_i);
    #1;
    n_cmp++;
    if (tick_o !== 5'b0) begin
      n_bad++;
      $display("FAIL R1 reset: actual %b expected 00000", tick_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2/R3/R4: windows of 480 cycles hold whole periods of every channel
    phase = "R2";
    repeat (20) @(negedge clk_i);
    fork
      count_win(0, 480, 120, "R2");
      count_win(1, 480, 60, "R4");
      count_win(2, 480, 60, "R3");
      count_win(3, 480, 15, "R4");
      count_win(4, 480, 60, "R5");
    join

    // R3: P=0 on group 0, shortest divide
    phase = "R3";
    @(negedge clk_i);
    cfg0_i[7:0] = 8'd0;
    repeat (10) @(negedge clk_i);
    count_win(0, 200, 100, "R3");

    // R8: change prescaler mid-period on group 1
    phase = "R8";
    @(negedge clk_i);
    cfg0_i[15:8] = 8'd9;
    repeat (2) @(negedge clk_i);
    cfg0_i[15:8] = 8'd2;
    repeat (60) @(negedge clk_i);
    count_win(2, 360, 60, "R8");

    // R9: code changes while running
    phase = "R9";
    set_code(3, 0);
    repeat (7) @(negedge clk_i);
    set_code(3, 7);
    repeat (13) @(negedge clk_i);
    set_code(2, 2);
    repeat (100) @(negedge clk_i);
    set_code(4, 2);
    count_win(4, 240, 10, "R9");

    // R6/R7: external sources
    phase = "R6";
    set_code(1, EXT_CODE);
    set_code(4, EXT_CODE);
    repeat (4) @(negedge clk_i);
    ext_tick_i = 2'b01;
    @(negedge clk_i);
    ext_tick_i = 2'b00;
    repeat (3) @(negedge clk_i);
    phase = "R7";
    ext_tick_i = 2'b11;
    count_win(1, 10, 1, "R7");
    ext_tick_i = 2'b00;
    count_win(4, 5, 0, "R7");
    for (int k = 0; k < 20; k++) begin
      ext_tick_i = 2'(k % 3 == 0 ? 3 : (k % 2));
      @(negedge clk_i);
    end
    ext_tick_i = 2'b00;
    for (int k = 0; k < 8; k++) begin
      ext_tick_i[1] = ~ext_tick_i[1];
      @(negedge clk_i);
    end
    ext_tick_i = 2'b00;
    count_win(1, 20, 0, "R6");

    // R1: reset mid-run clears everything
    phase = "R1";
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    n_cmp++;
    if (tick_o !== 5'b0) begin
      n_bad++;
      $display("FAIL R1 async reset: actual %b expected 00000", tick_o);
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    phase = "R5";
    repeat (300) @(negedge clk_i);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule